// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block supplies the address for every cycle of a synchronous burst memory. Two active-low strobes load a fresh base address from the address bus: one is meant for a processor and one for a memory controller. Both inputs are sampled on the rising clock edge. A load counts only when the chip is selected. Selection needs the active-low select low and the active-high select high. After a load, an active-low advance input steps a two-bit burst index. The index gives the burst position, so a burst has four beats.

A static order input chooses how the index maps onto the two low address bits. When the input is low the order is linear: the start value plus the index, modulo four. When it is high the order is interleaved: the start value XOR the index. A board leaves the pin unconnected to get interleaved order. The upper address bits keep their loaded value for the whole burst.

A strobe that arrives while the chip is deselected leaves the address alone and raises the deselect flag. The flag holds until the next selected load. All pins are plain control and status signals. There is no streamed data and so no valid/ready handshake or back-pressure. A new address can be loaded on any cycle, so bursts are optional.

Top module: `burst_addr_gen`

## Requirements
- R1: During and right after reset, `addr_o` is 0, `burst_idx_o` is 0 and `desel_o` is 1.
- R2: If either strobe is low at a rising edge while `cs_n`=0 and `cs`=1, then after that edge `addr_o` equals the sampled `addr_i`, `burst_idx_o` is 0 and `desel_o` is 0.
- R3: With both strobes high, `adv_n`=0 and `desel_o`=0, `burst_idx_o` increases by one, modulo 4, at the edge. With `adv_n`=1 it holds.
- R4: With `order_sel`=0 (linear), `addr_o[1:0]` equals (start bits + `burst_idx_o`) mod 4.
- R5: With `order_sel`=1 (interleaved), `addr_o[1:0]` equals start bits XOR `burst_idx_o`. For example, a start of 01 gives 01, 00, 11, 10.
- R6: After four advances, the index is back at 0 and the low address bits are back at the start bits.
- R7: Without a selected load, `addr_o[AW-1:2]` never changes. The counter never carries into the upper bits.
- R8: A strobe and an advance in the same cycle perform the load only.
- R9: A strobe while deselected (`cs_n`=1 or `cs`=0) leaves the address and index unchanged and sets `desel_o` to 1.
- R10: While `desel_o`=1, an advance has no effect on `burst_idx_o`.
- R11: Selected loads on consecutive cycles each take effect on their own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | External address bus |
| strobe_cpu_n | input | 1 | Processor load strobe, active low |
| strobe_ctl_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| cs_n | input | 1 | Chip select, active low |
| cs | input | 1 | Chip select, active high |
| addr_o | output | AW | Current burst address |
| burst_idx_o | output | CW | Beats taken since the last load |
| desel_o | output | 1 | Last strobe found the chip deselected |

## Verification
The hardest state to reach is a full four-beat wrap with no strobe in between. The same goes for advances that arrive while deselected. A random strobe on almost every cycle would cut such runs short. The stimulus therefore keeps strobes rare, at about one cycle in eight. It draws the select lines so that roughly a third of loads are deselected. Directed runs then walk a complete wrap in each order and press advance against a deselect.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    logic load;       // selected strobe: capture address
    logic desel_load; // strobe while deselected
    logic step;       // advance the burst index
  } cmd_t;

endpackage

// File: rtl/bag_cmd_decode.sv
module bag_cmd_decode
  import bag_pkg::*;
(
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic adv_n,
  input  logic cs_n,
  input  logic cs,
  input  logic desel_q,
  output cmd_t cmd
);

  logic any_strobe;
  logic selected;

  always_comb begin
    any_strobe     = ~strobe_cpu_n | ~strobe_ctl_n;
    selected       = ~cs_n & cs;
    cmd.load       = any_strobe & selected;
    cmd.desel_load = any_strobe & ~selected;
    // load has priority over advance
    cmd.step       = ~any_strobe & ~adv_n & ~desel_q;
  end

endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          desel_load,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] base_q,
  output logic          desel_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      desel_q <= 1'b1;
    end else if (load) begin
      base_q  <= addr_i;
      desel_q <= 1'b0;
    end else if (desel_load) begin
      desel_q <= 1'b1;
    end
  end

  // R9
  desel_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_load |=> desel_q && $stable(base_q));

endmodule

// File: rtl/bag_burst_cnt.sv
module bag_burst_cnt #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  output logic [CW-1:0] idx_q
);

  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx_q <= '0;
    else if (load)
      idx_q <= '0;
    else if (step)
      idx_q <= idx_q + ONE;
  end

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && (idx_q == {CW{1'b1}})) |=> (idx_q == '0));

endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] idx,
  input  order_e        order,
  output logic [CW-1:0] low
);

  logic [CW-1:0] lin_low;
  logic [CW-1:0] ilv_low;

  assign lin_low = start + idx;

  for (genvar b = 0; b < CW; b++) begin : g_ilv
    assign ilv_low[b] = start[b] ^ idx[b];
  end

  assign low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          strobe_cpu_n,
  input  logic          strobe_ctl_n,
  input  logic          adv_n,
  input  logic          order_sel,
  input  logic          cs_n,
  input  logic          cs,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] burst_idx_o,
  output logic          desel_o
);

  localparam int HW = AW - CW;

  cmd_t          cmd;
  logic [AW-1:0] base_q;
  logic          desel_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] low;

  bag_cmd_decode u_dec (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .cs_n         (cs_n),
    .cs           (cs),
    .desel_q      (desel_q),
    .cmd          (cmd)
  );

  bag_base_reg #(.AW(AW)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd.load),
    .desel_load (cmd.desel_load),
    .addr_i     (addr_i),
    .base_q     (base_q),
    .desel_q    (desel_q)
  );

  bag_burst_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd.load),
    .step  (cmd.step),
    .idx_q (idx_q)
  );

  bag_order_map #(.CW(CW)) u_map (
    .start (base_q[CW-1:0]),
    .idx   (idx_q),
    .order (order_e'(order_sel)),
    .low   (low)
  );

  assign addr_o      = {base_q[AW-1:CW], low};
  assign burst_idx_o = idx_q;
  assign desel_o     = desel_q;

  // R2
  sel_load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strobe_cpu_n || !strobe_ctl_n) && !cs_n && cs)
      |=> (addr_o[AW-1:CW] == $past(addr_i[AW-1:CW])) && (burst_idx_o == '0) && !desel_o);

  // R3
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu_n && strobe_ctl_n && !adv_n && !desel_o)
      |=> (burst_idx_o == ($past(burst_idx_o) + CW'(1))));

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu_n && strobe_ctl_n) |=> $stable(addr_o[AW-1:CW]));

  // R10
  desel_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu_n && strobe_ctl_n && desel_o) |=> desel_o && $stable(burst_idx_o));

  // R2 width bookkeeping: the upper field must be non-empty
  initial begin
    upper_width_chk: assert (HW > 0);
  end

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int AW = 20;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          strobe_cpu_n, strobe_ctl_n, adv_n, order_sel, cs_n, cs;
  logic [AW-1:0] addr_o;
  logic [CW-1:0] burst_idx_o;
  logic          desel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [AW-1:0] m_base;
  logic [CW-1:0] m_idx;
  logic          m_desel;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW), .CW(CW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .adv_n(adv_n), .order_sel(order_sel), .cs_n(cs_n), .cs(cs),
    .addr_o(addr_o), .burst_idx_o(burst_idx_o), .desel_o(desel_o)
  );

  function automatic logic [CW-1:0] exp_low(input logic [CW-1:0] st,
                                            input logic [CW-1:0] ix,
                                            input logic ord);
    return ord ? (st ^ ix) : CW'(st + ix);
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_base[AW-1:CW], exp_low(m_base[CW-1:0], m_idx, order_sel)};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(addr_o == exp_addr(), tag, 64'(addr_o), 64'(exp_addr()));
    chk(burst_idx_o == m_idx, tag, 64'(burst_idx_o), 64'(m_idx));
    chk(desel_o == m_desel, tag, 64'(desel_o), 64'(m_desel));
  endtask

  task automatic idle();
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
  endtask

  // one clock: model updates from the driven inputs, outputs checked at negedge
  task automatic cyc(input string tag);
    bit strb, sel;
    @(posedge clk);
    strb = !strobe_cpu_n || !strobe_ctl_n;
    sel  = !cs_n && cs;
    if (strb && sel) begin
      m_base = addr_i; m_idx = '0; m_desel = 1'b0;
    end else if (strb) begin
      m_desel = 1'b1;
    end else if (!adv_n && !m_desel) begin
      m_idx = m_idx + CW'(1);
    end
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic load(input logic [AW-1:0] a, input bit use_cpu, input string tag);
    idle();
    addr_i = a; cs_n = 1'b0; cs = 1'b1;
    if (use_cpu) strobe_cpu_n = 1'b0; else strobe_ctl_n = 1'b0;
    cyc(tag);
    idle();
  endtask

  initial begin
    int unused_seed;
    logic [AW-1:0] up_before;
    logic [CW-1:0] seq_lin [4];
    logic [CW-1:0] seq_ilv [4];
    unused_seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0; addr_i = '0; order_sel = 1'b0; cs_n = 1'b1; cs = 1'b0;
    idle();
    m_base = '0; m_idx = '0; m_desel = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(addr_o == '0, "R1 addr", 64'(addr_o), 64'd0);
    chk(burst_idx_o == '0, "R1 idx", 64'(burst_idx_o), 64'd0);
    chk(desel_o == 1'b1, "R1 desel", 64'(desel_o), 64'd1);
    rst_n = 1'b1;
    cyc("R1 after release");

    // R2 + R4 + R6: linear wrap from start 01
    order_sel = 1'b0;
    load(20'hABCD1, 1'b1, "R2 cpu load");
    seq_lin = '{2'b01, 2'b10, 2'b11, 2'b00};
    for (int i = 1; i <= 4; i++) begin
      adv_n = 1'b0;
      cyc("R4 linear step");
      chk(addr_o[1:0] == seq_lin[i % 4], "R4 linear seq",
          64'(addr_o[1:0]), 64'(seq_lin[i % 4]));
    end
    chk(addr_o == 20'hABCD1, "R6 wrap to start", 64'(addr_o), 64'hABCD1);
    chk(burst_idx_o == '0, "R6 idx wrap", 64'(burst_idx_o), 64'd0);
    adv_n = 1'b1;
    cyc("R3 hold without advance");

    // R5: interleaved from 01 -> 01 00 11 10, controller strobe
    order_sel = 1'b1;
    load(20'h12341, 1'b0, "R2 ctl load");
    seq_ilv = '{2'b01, 2'b00, 2'b11, 2'b10};
    for (int i = 1; i <= 4; i++) begin
      adv_n = 1'b0;
      cyc("R5 interleave step");
      chk(addr_o[1:0] == seq_ilv[i % 4], "R5 interleave seq",
          64'(addr_o[1:0]), 64'(seq_ilv[i % 4]));
    end
    chk(addr_o == 20'h12341, "R6 interleave wrap", 64'(addr_o), 64'h12341);

    // R8: strobe plus advance, load wins
    adv_n = 1'b0; cyc("R3 pre-step");
    addr_i = 20'h55552; cs_n = 1'b0; cs = 1'b1; strobe_cpu_n = 1'b0; adv_n = 1'b0;
    cyc("R8 load over advance");
    chk(burst_idx_o == '0, "R8 idx", 64'(burst_idx_o), 64'd0);
    idle();

    // R9: deselected strobe via each select
    up_before = addr_o;
    addr_i = 20'h0FFF3; cs_n = 1'b1; cs = 1'b1; strobe_ctl_n = 1'b0;
    cyc("R9 desel by cs_n");
    chk(addr_o == up_before && desel_o, "R9 addr kept", 64'(addr_o), 64'(up_before));
    idle();
    cs_n = 1'b0; cs = 1'b0; strobe_cpu_n = 1'b0;
    cyc("R9 desel by cs");
    idle();

    // R10: advances while deselected
    for (int i = 0; i < 3; i++) begin
      adv_n = 1'b0;
      cyc("R10 adv ignored");
      chk(burst_idx_o == '0, "R10 idx", 64'(burst_idx_o), 64'd0);
    end
    idle();

    // R11: back-to-back loads
    for (int i = 0; i < 4; i++) begin
      addr_i = AW'(20'h30000 + i * 20'h1111); cs_n = 1'b0; cs = 1'b1;
      strobe_cpu_n = i[0]; strobe_ctl_n = ~i[0];
      cyc("R11 back-to-back");
      chk(addr_o[AW-1:2] == addr_i[AW-1:2], "R11 upper", 64'(addr_o), 64'(addr_i));
    end
    idle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      string tag;
      bit strb;
      if (($urandom % 200) == 0) order_sel = ~order_sel;
      addr_i = AW'($urandom);
      strb = (($urandom % 8) == 0);
      strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1;
      if (strb) begin
        if ($urandom % 2) strobe_cpu_n = 1'b0; else strobe_ctl_n = 1'b0;
      end
      cs_n = (($urandom % 6) == 0);
      cs   = (($urandom % 6) != 0);
      adv_n = (($urandom % 4) == 0);
      up_before = addr_o;
      if (strb && !cs_n && cs)       tag = "R2 random load";
      else if (strb)                 tag = "R9 random desel";
      else if (!adv_n && m_desel)    tag = "R10 random adv";
      else if (!adv_n && order_sel)  tag = "R5 random step";
      else if (!adv_n)               tag = "R4 random step";
      else                           tag = "R3 random hold";
      cyc(tag);
      if (!(strb && !cs_n && cs))
        chk(addr_o[AW-1:2] == up_before[AW-1:2], "R7 upper stable",
            64'(addr_o[AW-1:2]), 64'(up_before[AW-1:2]));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule